// File: doc/BRIEF.md
# Fault Recording Ring

This block keeps a small circular bank of fault records. Each record is four 32-bit words. A fault source presents a 127-bit payload together with a one-cycle strobe. The block stores the payload in the record under its own write pointer, marks the record as occupied and moves the pointer on. Software reads the records and a status word through a simple word-addressed register port. It frees a record by writing one to that record's occupied flag.

Recording is strictly in order. If the record under the pointer is still occupied, the incoming fault is lost and a sticky overflow bit is raised. This happens even when other records are free. The status word also reports a pending-fault bit and the index of the first record written since software last cleared pending. A level interrupt, gated by an enable bit, reflects pending and overflow.

Top module: `fault_ring`

## Requirements
- R1: After reset every occupied flag is 0, the status word reads 0, the control word reads 0, irq is 0, and the write pointer is 0, so the first recorded fault lands in record 0.
- R2: A strobed fault whose target record is free is stored in that record. Payload bits 31:0, 63:32 and 95:64 go to words 0, 1 and 2. Payload bits 126:96 go to word 3 bits 30:0. Word 3 bit 31 (the occupied flag) becomes 1, and the pointer advances by one, wrapping from N_ENT-1 to 0.
- R3: A strobed fault whose target record is occupied is dropped. The record keeps its contents, the pointer does not move, and the overflow bit is set.
- R4: Writing 1 to word 3 bit 31 of a record clears its occupied flag. All other record bits ignore software writes.
- R5: Status bits 15:8 hold the fault record index. It is loaded with the pointer value when a record is made while the pending bit, as it stood before that cycle, is 0. Otherwise it holds.
- R6: Status bit 1 (pending) is set by every successful record and is cleared when software writes 1 to it. A record in the same cycle wins.
- R7: Status bit 0 (overflow) is sticky and is cleared when software writes 1 to it. A drop in the same cycle wins.
- R8: irq equals (pending OR overflow) AND the enable bit. The enable bit is control word bit 0, which is readable and writable.
- R9: A fault that arrives in the same cycle as a software clear of its target record's flag is recorded.
- R10: Word address 4*e+w selects record e, word w. Address 4*N_ENT is the status word and address 4*N_ENT+1 is the control word. Reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flt_vld | input | 1 | Fault strobe, one cycle per fault |
| flt_data | input | 127 | Fault payload |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | AW | Word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with its default of eight records, which gives a three-bit pointer and index. With so few records, a short burst fills the whole ring, so drops, pointer wrap and repeated overflow are all reached often. The random phase clears records sparsely and at random, so the pointer often meets an occupied record while free ones exist elsewhere. Clearing pending at random hits both ways the record index can be loaded.

// File: rtl/fault_ring.sv
module fault_ring #(
  parameter int N_ENT = 8,
  localparam int PW = (N_ENT > 1) ? $clog2(N_ENT) : 1,
  localparam int AW = $clog2(4 * N_ENT + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flt_vld,
  input  logic [126:0]  flt_data,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          irq
);

  localparam logic [AW-1:0] ST_A = AW'(4 * N_ENT);
  localparam logic [AW-1:0] CT_A = AW'(4 * N_ENT + 1);
  localparam logic [PW-1:0] LAST = PW'(N_ENT - 1);

  logic [126:0]     row [N_ENT];
  logic [N_ENT-1:0] vld;
  logic [N_ENT-1:0] clr_vec;
  logic [PW-1:0]    ptr, fri;
  logic             ovf, pend, ien;

  wire            sw_ent = reg_addr < ST_A;
  wire [PW-1:0]   sw_idx = PW'(reg_addr >> 2);
  wire            st_wr  = reg_we && reg_addr == ST_A;
  wire            ct_wr  = reg_we && reg_addr == CT_A;

  always_comb begin
    for (int e = 0; e < N_ENT; e++)
      clr_vec[e] = reg_we && sw_ent && reg_addr[1:0] == 2'd3 &&
                   reg_wdata[31] && sw_idx == PW'(e);
  end

  wire occ  = vld[ptr] && !clr_vec[ptr];
  wire rec  = flt_vld && !occ;
  wire drop = flt_vld && occ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= '0;
      for (int e = 0; e < N_ENT; e++) row[e] <= '0;
    end else begin
      for (int e = 0; e < N_ENT; e++) begin
        if (rec && ptr == PW'(e)) begin
          row[e] <= flt_data;
          vld[e] <= 1'b1;
        end else if (clr_vec[e]) begin
          vld[e] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr  <= '0;
      fri  <= '0;
      ovf  <= 1'b0;
      pend <= 1'b0;
      ien  <= 1'b0;
    end else begin
      if (rec) ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
      if (rec && !pend) fri <= ptr;
      if (rec) pend <= 1'b1;
      else if (st_wr && reg_wdata[1]) pend <= 1'b0;
      if (drop) ovf <= 1'b1;
      else if (st_wr && reg_wdata[0]) ovf <= 1'b0;
      if (ct_wr) ien <= reg_wdata[0];
    end
  end

  assign irq = ien & (pend | ovf);

  logic [126:0] rd_row;
  assign rd_row = row[sw_idx];

  always_comb begin
    reg_rdata = '0;
    if (sw_ent) begin
      case (reg_addr[1:0])
        2'd0: reg_rdata = rd_row[31:0];
        2'd1: reg_rdata = rd_row[63:32];
        2'd2: reg_rdata = rd_row[95:64];
        default: reg_rdata = {vld[sw_idx], rd_row[126:96]};
      endcase
    end else if (reg_addr == ST_A) begin
      reg_rdata = (32'(fri) << 8) | {30'd0, pend, ovf};
    end else if (reg_addr == CT_A) begin
      reg_rdata = {31'd0, ien};
    end
  end

endmodule

// File: rtl/fault_ring_chk.sv
module fault_ring_chk #(
  parameter int N_ENT = 8,
  parameter int PW = 3,
  parameter int AW = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flt_vld,
  input logic             reg_we,
  input logic [AW-1:0]    reg_addr,
  input logic [31:0]      reg_wdata,
  input logic             irq,
  input logic [PW-1:0]    ptr,
  input logic [N_ENT-1:0] vld,
  input logic             ovf,
  input logic             pend,
  input logic             ien,
  input logic [PW-1:0]    fri
);

  wire tgt_clr = reg_we && reg_wdata[31] && reg_addr == AW'({ptr, 2'b11});
  wire occ_c   = vld[ptr] && !tgt_clr;
  wire st_w    = reg_we && reg_addr == AW'(4 * N_ENT);
  wire [PW-1:0] nxt = (ptr == PW'(N_ENT - 1)) ? '0 : ptr + 1'b1;

  AST_DROP_HOLDS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    flt_vld && occ_c |=> $stable(ptr) && ovf); // R3
  AST_REC_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    flt_vld && !occ_c |=> ptr == $past(nxt) && vld[$past(ptr)] && pend); // R2
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && !(st_w && reg_wdata[0]) |=> ovf); // R7
  AST_FRI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    pend && !(st_w && reg_wdata[1]) |=> $stable(fri) && pend); // R5
  AST_IRQ_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    !ien |-> !irq); // R8
  AST_SAME_CYCLE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    flt_vld && vld[ptr] && tgt_clr |=> vld[$past(ptr)]); // R9

endmodule

bind fault_ring fault_ring_chk #(.N_ENT(N_ENT), .PW(PW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .flt_vld(flt_vld), .reg_we(reg_we),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .irq(irq), .ptr(ptr),
  .vld(vld), .ovf(ovf), .pend(pend), .ien(ien), .fri(fri)
);

// File: tb/fault_ring_tb.sv
module fault_ring_tb;
  localparam int N  = 8;
  localparam int AW = $clog2(4 * N + 2);
  localparam int STA = 4 * N;
  localparam int CTA = 4 * N + 1;

  logic clk = 0, rst_n = 0;
  logic flt_vld = 0;
  logic [126:0] flt_data = '0;
  logic reg_we = 0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic irq;

  fault_ring #(.N_ENT(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .flt_vld(flt_vld), .flt_data(flt_data),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic [126:0] m_row [N];
  bit m_vld [N];
  int m_ptr = 0, m_fri = 0;
  bit m_ovf = 0, m_pend = 0, m_ien = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%08h exp=%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] m_word(int a);
    int e = a / 4;
    if (a < STA) begin
      case (a % 4)
        0: return m_row[e][31:0];
        1: return m_row[e][63:32];
        2: return m_row[e][95:64];
        default: return {m_vld[e], m_row[e][126:96]};
      endcase
    end
    if (a == STA) return {16'd0, 8'(m_fri), 6'd0, m_pend, m_ovf};
    if (a == CTA) return {31'd0, m_ien};
    return '0;
  endfunction

  function automatic logic [126:0] rnd_pay();
    logic [127:0] t = {$urandom, $urandom, $urandom, $urandom};
    return t[126:0];
  endfunction

  task automatic m_step(bit fv, logic [126:0] fd, bit we, int a, logic [31:0] wd);
    bit old_pend = m_pend;
    bit clr = we && a < STA && a % 4 == 3 && wd[31];
    bit occ = m_vld[m_ptr] && !(clr && a / 4 == m_ptr);
    if (clr) m_vld[a / 4] = 0;
    if (we && a == STA) begin
      if (wd[0]) m_ovf = 0;
      if (wd[1]) m_pend = 0;
    end
    if (we && a == CTA) m_ien = wd[0];
    if (fv) begin
      if (occ) m_ovf = 1;
      else begin
        m_row[m_ptr] = fd;
        m_vld[m_ptr] = 1;
        if (!old_pend) m_fri = m_ptr;
        m_pend = 1;
        m_ptr = (m_ptr + 1) % N;
      end
    end
  endtask

  task automatic cyc(bit fv, logic [126:0] fd, bit we, int a, logic [31:0] wd);
    flt_vld = fv; flt_data = fd; reg_we = we; reg_addr = AW'(a); reg_wdata = wd;
    @(posedge clk);
    m_step(fv, fd, we, a, wd);
    @(negedge clk);
    flt_vld = 0; reg_we = 0;
  endtask

  task automatic rd_chk(string req, int a);
    reg_addr = AW'(a);
    #1;
    chk(req, reg_rdata, m_word(a));
  endtask

  task automatic chk_status();
    reg_addr = AW'(STA);
    #1;
    chk("R7 overflow", {31'd0, reg_rdata[0]}, {31'd0, m_ovf});
    chk("R6 pending", {31'd0, reg_rdata[1]}, {31'd0, m_pend});
    chk("R5 index", {24'd0, reg_rdata[15:8]}, 32'(m_fri));
    chk("R8 irq", {31'd0, irq}, {31'd0, m_ien & (m_pend | m_ovf)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=running exp=done");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [126:0] p0, p1;
    void'($urandom(32'd1234));
    for (int e = 0; e < N; e++) begin m_row[e] = '0; m_vld[e] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < STA; a += 4) rd_chk("R1 entry", a + 3);
    rd_chk("R1 status", STA);
    rd_chk("R1 control", CTA);
    chk("R1 irq", {31'd0, irq}, 32'd0);

    // R8 enable, R2 fill the ring from record 0
    cyc(0, '0, 1, CTA, 32'd1);
    rd_chk("R8 control", CTA);
    p0 = rnd_pay();
    cyc(1, p0, 0, 0, 0);
    for (int w = 0; w < 4; w++) rd_chk("R2 first record", w);
    chk_status();
    for (int i = 1; i < N; i++) cyc(1, rnd_pay(), 0, 0, 0);
    for (int a = 0; a < STA; a++) rd_chk("R2 records", a);

    // R3 drop at full ring
    p1 = rnd_pay();
    cyc(1, p1, 0, 0, 0);
    for (int w = 0; w < 4; w++) rd_chk("R3 record kept", w);
    chk_status();

    // R4 non-flag writes ignored
    cyc(0, '0, 1, 0, 32'hFFFF_FFFF);
    cyc(0, '0, 1, 3, 32'h7FFF_FFFF);
    rd_chk("R4 word0 kept", 0);
    rd_chk("R4 word3 kept", 3);

    // R9 clear and fault on pointer record in same cycle
    cyc(1, p1, 1, 3, 32'h8000_0000);
    for (int w = 0; w < 4; w++) rd_chk("R9 recorded", w);

    // R6 R7 W1C, then R5 index reload from pointer 1
    cyc(0, '0, 1, STA, 32'h3);
    chk_status();
    cyc(0, '0, 1, 7, 32'h8000_0000);
    rd_chk("R4 flag cleared", 7);
    cyc(1, rnd_pay(), 0, 0, 0);
    chk_status();
    chk("R5 index one", 32'(m_fri), 32'd1);

    // random phase, R10 mapping via random reads
    for (int i = 0; i < 4000; i++) begin
      int k = $urandom % 10;
      int a = 0;
      bit we = 0;
      logic [31:0] wd = $urandom;
      if (k < 4) begin we = 1; a = ($urandom % N) * 4 + 3; wd[31] = ($urandom % 4) != 0; end
      else if (k == 4) begin we = 1; a = $urandom % STA; end
      else if (k == 5) begin we = 1; a = STA; end
      else if (k == 6) begin we = 1; a = CTA; wd[0] = ($urandom % 4) != 0; end
      cyc(($urandom % 5) < 2, rnd_pay(), we, a, wd);
      chk_status();
      rd_chk("R10 random read", $urandom % (STA + 2));
    end

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule